// File: doc/BRIEF.md
# Banked Program Memory Address Mapper

This block sits between a core's 12-bit program counter and a program memory larger than 4 KB. It splits the 4 KB window the counter can reach into two halves. The lower 2 KB always goes to one common base block, which holds the low page of reset, interrupt and short-call entry points. The upper 2 KB is redirected into one of several switchable 2 KB blocks, chosen by a small bank register. With the default of four switchable blocks, the reachable physical space is 10 KB, addressed by a 14-bit physical address.

Software writes the bank register through a narrow bus write port and can read it back on the same bus width. A written value takes effect from the clock edge that captures it. A value that names a bank that is not built is clamped to the highest bank that is, so an address outside the memory is never produced.

A separate gate passes data from the memory to an external reader only when a protection lock is clear. While the lock is set, the reader sees zero and no grant.

Top module: `bank_mapper`

## Requirements
- R1: When pc[11] is 0, phys_addr equals pc zero-extended to 14 bits, whatever the bank register holds.
- R2: When pc[11] is 1, phys_addr[10:0] equals pc[10:0] and phys_addr[13:11] equals the bank register value plus one, so banks 0..3 land in physical 2 KB blocks 1..4.
- R3: A synchronous active-low reset sets the bank register to 0, and takes priority over a write in the same cycle.
- R4: A write (bank_wr_en high at a rising edge) changes the bank register at that edge, so translation uses the new bank from that edge on. Without a write, the register holds its value.
- R5: bank_rd_data always returns the current bank number, zero-extended to 4 bits.
- R6: A written value of 4 or more is stored as 3, so phys_addr never reaches 0x2800.
- R7: Addresses 0x000 to 0x1FF (the entry-point page) map to the identical physical address for every bank value.
- R8: ext_rd_grant equals ext_rd_req AND NOT ext_lock. ext_rd_data equals mem_rdata when the grant is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc | input | 12 | Program counter from the core |
| bank_wr_en | input | 1 | Bank register write strobe |
| bank_wr_data | input | 4 | Bank number to write |
| bank_rd_data | output | 4 | Current bank number |
| phys_addr | output | 14 | Physical program-memory address |
| ext_rd_req | input | 1 | External read request |
| ext_lock | input | 1 | Read protection lock |
| mem_rdata | input | 8 | Data from the program memory |
| ext_rd_grant | output | 1 | External read allowed |
| ext_rd_data | output | 8 | Gated data to the external reader |

## Verification
The only internal state is the bank register. A wrong value in it shows up at once on bank_rd_data. It also shows up on the top three bits of phys_addr in the same cycle as any fetch from the upper half, and it stays invisible to lower-half fetches. The bench therefore compares read-back and translation every cycle, both just before and just after each write edge. A write that lands one cycle late, or is missing, is caught in the first cycle afterwards. Clamping errors appear the moment an out-of-range value is written.

// File: rtl/bank_mapper_pkg.sv
// Package: shared constants and types for the banked address mapper.
// Assumes a 12-bit program counter whose top bit selects the window half.
package bank_mapper_pkg;
    localparam int PC_W   = 12;
    localparam int HALF_W = PC_W - 1;

    typedef logic [PC_W-1:0] pc_t;

    typedef enum logic {
        WIN_BASE   = 1'b0,
        WIN_BANKED = 1'b1
    } win_half_e;
endpackage

// File: rtl/bank_sel_reg.sv
// bank_sel_reg: holds the selected switchable bank.
// Clamps out-of-range writes to the highest built bank. Reset is synchronous,
// active low, and wins over a write in the same cycle.
module bank_sel_reg #(
    parameter int BANKS  = 4,
    parameter int BANK_W = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_data,
    output logic [SEL_W-1:0]  sel,
    output logic [BANK_W-1:0] rd_data
);
    localparam logic [BANK_W-1:0] MAX_SEL = BANK_W'(BANKS - 1);

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] wr_clamped;

    // Limit a written value to the implemented bank range.
    always_comb begin
        if (wr_data > MAX_SEL) wr_clamped = MAX_SEL[SEL_W-1:0];
        else                   wr_clamped = wr_data[SEL_W-1:0];
    end

    // Capture a new bank number on a write; return to bank 0 on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (wr_en) sel_q <= wr_clamped;
    end

    assign sel     = sel_q;
    assign rd_data = BANK_W'(sel_q);
endmodule

// File: rtl/addr_xlate.sv
// addr_xlate: combinational translation of pc into a physical address.
// The lower half passes through; the upper half goes to block sel+1.
module addr_xlate
    import bank_mapper_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int PHYS_W = 14
) (
    input  pc_t               pc,
    input  logic [SEL_W-1:0]  sel,
    output logic [PHYS_W-1:0] phys
);
    localparam int BLK_W = PHYS_W - HALF_W;

    win_half_e        half;
    logic [BLK_W-1:0] blk;

    // Decide which half of the window the fetch falls in.
    always_comb half = win_half_e'(pc[PC_W-1]);

    // Switchable block index: bank 0 sits just above the base block.
    always_comb blk = BLK_W'(sel) + BLK_W'(1);

    // Form the physical address for the chosen half.
    always_comb begin
        if (half == WIN_BANKED) phys = {blk, pc[HALF_W-1:0]};
        else                    phys = PHYS_W'(pc);
    end
endmodule

// File: rtl/ext_read_gate.sv
// ext_read_gate: passes memory data to an external reader only while the
// protection lock is clear; otherwise the reader sees zeros.
module ext_read_gate #(
    parameter int DATA_W = 8
) (
    input  logic              req,
    input  logic              lock,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              grant,
    output logic [DATA_W-1:0] rdata
);
    // Grant a read only when requested and unlocked.
    assign grant = req & ~lock;

    // Mask every data bit with the grant.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign rdata[i] = mem_rdata[i] & grant;
    end
endmodule

// File: rtl/bank_mapper.sv
// bank_mapper: top of the banked program memory address mapper.
// Assumes BANKS >= 1 switchable 2 KB blocks above one common base block.
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int BANK_W = 4,
    parameter int DATA_W = 8,
    parameter int SEL_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
    parameter int PHYS_W = $clog2((BANKS + 1) * (1 << HALF_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc,
    input  logic              bank_wr_en,
    input  logic [BANK_W-1:0] bank_wr_data,
    output logic [BANK_W-1:0] bank_rd_data,
    output logic [PHYS_W-1:0] phys_addr,
    input  logic              ext_rd_req,
    input  logic              ext_lock,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ext_rd_grant,
    output logic [DATA_W-1:0] ext_rd_data
);
    logic [SEL_W-1:0] sel;

    bank_sel_reg #(.BANKS(BANKS), .BANK_W(BANK_W), .SEL_W(SEL_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr_en),
        .wr_data (bank_wr_data),
        .sel     (sel),
        .rd_data (bank_rd_data)
    );

    addr_xlate #(.SEL_W(SEL_W), .PHYS_W(PHYS_W)) u_xlate (
        .pc   (pc),
        .sel  (sel),
        .phys (phys_addr)
    );

    ext_read_gate #(.DATA_W(DATA_W)) u_gate (
        .req       (ext_rd_req),
        .lock      (ext_lock),
        .mem_rdata (mem_rdata),
        .grant     (ext_rd_grant),
        .rdata     (ext_rd_data)
    );
endmodule

// File: rtl/bank_mapper_chk.sv
// bank_mapper_chk: property checks on the mapper's ports, bound to the top.
module bank_mapper_chk #(
    parameter int BANKS  = 4,
    parameter int BANK_W = 4,
    parameter int DATA_W = 8,
    parameter int PHYS_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [11:0]       pc,
    input logic              bank_wr_en,
    input logic [BANK_W-1:0] bank_wr_data,
    input logic [BANK_W-1:0] bank_rd_data,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              ext_rd_req,
    input logic              ext_lock,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              ext_rd_grant,
    input logic [DATA_W-1:0] ext_rd_data
);
    localparam logic [BANK_W-1:0] MAX_SEL = BANK_W'(BANKS - 1);
    localparam logic [PHYS_W:0]   LIMIT   = (PHYS_W+1)'((BANKS + 1) * 2048);

    a_r1_base_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !pc[11] |-> phys_addr == PHYS_W'(pc));

    a_r2_banked_block: assert property (@(posedge clk) disable iff (!rst_n)
        pc[11] |-> (phys_addr[10:0] == pc[10:0]) &&
                   (PHYS_W'(phys_addr[PHYS_W-1:11]) == PHYS_W'(bank_rd_data) + PHYS_W'(1)));

    a_r3_reset_bank0: assert property (@(posedge clk)
        !rst_n |=> bank_rd_data == '0);

    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr_en |=> $stable(bank_rd_data));

    a_r6_clamped_write: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_en |=> bank_rd_data ==
            (($past(bank_wr_data) > MAX_SEL) ? MAX_SEL : $past(bank_wr_data)));

    a_r6_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (PHYS_W+1)'(phys_addr) < LIMIT);

    a_r5_readback_range: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rd_data <= MAX_SEL);

    a_r8_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ext_lock |-> !ext_rd_grant && ext_rd_data == '0);
endmodule

bind bank_mapper bank_mapper_chk #(
    .BANKS(BANKS), .BANK_W(BANK_W), .DATA_W(DATA_W), .PHYS_W(PHYS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pc(pc), .bank_wr_en(bank_wr_en),
    .bank_wr_data(bank_wr_data), .bank_rd_data(bank_rd_data),
    .phys_addr(phys_addr), .ext_rd_req(ext_rd_req), .ext_lock(ext_lock),
    .mem_rdata(mem_rdata), .ext_rd_grant(ext_rd_grant), .ext_rd_data(ext_rd_data)
);

// File: tb/bank_mapper_bench.sv
// bank_mapper_bench: directed corners plus seeded random stimulus, checked
// against a bench-side model of the bank register and the address map.
module bank_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] pc;
    logic        we;
    logic [3:0]  wd;
    logic [3:0]  rd;
    logic [13:0] phys;
    logic        req, lock;
    logic [7:0]  mdata;
    logic        grant;
    logic [7:0]  edata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int m_bank = 0;

    always #10 clk = ~clk;

    bank_mapper u_bank_mapper (
        .clk(clk), .rst_n(rst_n), .pc(pc), .bank_wr_en(we), .bank_wr_data(wd),
        .bank_rd_data(rd), .phys_addr(phys), .ext_rd_req(req), .ext_lock(lock),
        .mem_rdata(mdata), .ext_rd_grant(grant), .ext_rd_data(edata)
    );

    function automatic int clampf(input logic [3:0] w);
        return (w > 4'd3) ? 3 : int'(w);
    endfunction

    function automatic logic [13:0] exp_phys(input logic [11:0] p, input int b);
        if (p[11]) return {3'(b + 1), p[10:0]};
        return {2'b00, p};
    endfunction

    task automatic chk(input string req_s, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req_s, what, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        if (pc[11]) chk("R2", {tag, " phys"}, 32'(phys), 32'(exp_phys(pc, m_bank)));
        else        chk("R1", {tag, " phys"}, 32'(phys), 32'(exp_phys(pc, m_bank)));
        chk("R5", {tag, " readback"}, 32'(rd), 32'(m_bank));
        chk("R8", {tag, " grant"}, 32'(grant), 32'(req & ~lock));
        chk("R8", {tag, " data"}, 32'(edata), (req & ~lock) ? 32'(mdata) : 32'd0);
    endtask

    // One clock: drive after the falling edge, check before and after the rising edge.
    task automatic step(input logic r, input logic [11:0] p, input logic w,
                        input logic [3:0] d, input logic q, input logic l,
                        input logic [7:0] m);
        rst_n = r; pc = p; we = w; wd = d; req = q; lock = l; mdata = m;
        #2;
        if (rst_n) chk("R4", "bank unchanged before edge", 32'(rd), 32'(m_bank));
        @(posedge clk);
        if (!rst_n)  m_bank = 0;
        else if (we) m_bank = clampf(wd);
        @(negedge clk);
        check_outs("post-edge");
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd5381);
        rst_n = 1'b0; pc = '0; we = 1'b0; wd = '0; req = 1'b0; lock = 1'b0; mdata = '0;
        @(negedge clk);
        // R3: reset wins over a simultaneous write.
        step(1'b0, 12'h800, 1'b1, 4'd2, 1'b0, 1'b0, 8'h00);
        step(1'b0, 12'h800, 1'b1, 4'd2, 1'b0, 1'b0, 8'h00);
        chk("R3", "reset bank", 32'(rd), 32'd0);
        chk("R3", "reset phys", 32'(phys), 32'h0800);
        // R2/R6: highest bank, top of window.
        step(1'b1, 12'hFFF, 1'b1, 4'd3, 1'b1, 1'b0, 8'hA5);
        chk("R6", "top address", 32'(phys), 32'h27FF);
        // R6: out-of-range writes clamp to 3.
        step(1'b1, 12'h000, 1'b1, 4'd0, 1'b0, 1'b0, 8'h00);
        step(1'b1, 12'h9AB, 1'b1, 4'd9, 1'b0, 1'b0, 8'h00);
        chk("R6", "clamp 9", 32'(rd), 32'd3);
        step(1'b1, 12'h9AB, 1'b1, 4'd4, 1'b0, 1'b0, 8'h00);
        chk("R6", "clamp 4", 32'(rd), 32'd3);
        chk("R6", "clamp 4 phys", 32'(phys), 32'h21AB);
        // R7: entry-point page is identical for every bank.
        for (int b = 0; b < 4; b++) begin
            step(1'b1, 12'h1FF, 1'b1, 4'(b), 1'b0, 1'b0, 8'h00);
            chk("R7", "zero page top", 32'(phys), 32'h01FF);
        end
        // R4: holding without write.
        step(1'b1, 12'h800, 1'b1, 4'd1, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 12'h800, 1'b0, 4'd2, 1'b0, 1'b0, 8'h00);
            chk("R4", "held bank", 32'(rd), 32'd1);
        end
        chk("R4", "held phys", 32'(phys), 32'h1000);
        // R8: lock masks data.
        step(1'b1, 12'h123, 1'b0, 4'd0, 1'b1, 1'b1, 8'hFF);
        chk("R8", "locked data", 32'(edata), 32'd0);
        // Random mix.
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 50) != 0, 12'($urandom), ($urandom % 4) == 0,
                 4'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule